// File: doc/BRIEF.md
# Presence-Detect EEPROM Slave

This block is a two-wire serial slave that serves a 256-byte memory over a clock line and an open-drain data line. A system clock samples both bus lines, and the block detects START and STOP from them. It answers one of eight bus addresses, chosen by three strap inputs, and acknowledges every byte it accepts.

After a write address, the first data byte loads an internal pointer. Each later byte is stored at the pointer, which then advances. After a read address, the slave sends bytes from the pointer for as long as the master acknowledges them.

The memory has two halves. The lower half holds module identification data and can be locked with a write-protect input. The upper half always stays writable. The slave never drives the data line high. It only asserts a pull-low enable, and the pad or the board resolves the line.

Top module: `spd_eeprom_slave`

## Requirements
- R1: A START is the data line falling while the clock line is high. While idle after reset, the slave ignores all clocked bits and acknowledges nothing until a START has been seen.
- R2: The slave acknowledges an address byte only when its upper four bits are 1010 and bits 3..1 equal `strap_i[2:0]`; bit 0 selects read (1) or write (0). After a mismatch it stays silent, and acknowledges no further byte until the next START.
- R3: The slave acknowledges by pulling the data line low during the ninth clock after a matching address byte, and after every byte received in write mode.
- R4: The first byte after a write address loads the pointer. Each later byte is stored at the pointer, after which the pointer increments modulo 256, so a write at 0xFF continues at 0x00.
- R5: In read mode the slave sends the byte at the pointer, most significant bit first, and increments the pointer modulo 256. While the master acknowledges, it sends the next byte.
- R6: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing until a START or STOP.
- R7: A STOP (the data line rising while the clock line is high) returns the slave to idle. Bytes clocked after it without a new START are not acknowledged.
- R8: While `wp_i` is high, bytes aimed at addresses 0x00..0x7F are acknowledged but leave the memory unchanged. Bytes aimed at 0x80..0xFF are written regardless of `wp_i`.
- R9: A repeated START followed by a read address keeps the pointer set by an earlier write, so a random read returns data from that location.
- R10: Out of reset, and whenever idle, the slave does not pull the data line.
- R11: The slave never pulls the data line while the master is sending the eight data bits of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| strap_i | input | 3 | Board straps selecting the bus address |
| wp_i | input | 1 | Write protect for the lower half of the memory |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data pad |

## Verification
The bench goes after three groups of corner cases.

- **Pointer wrap.** It writes and reads across the 0x7F/0x80 boundary and across 0xFF/0x00. A pointer that saturates instead of wrapping, or that increments at the wrong point, returns the wrong bytes.
- **Bus state.** It sends bytes before any START and after a STOP, and it sends an address with one strap bit flipped for every strap value. A slave that wakes on data alone acknowledges those bytes.
- **Read termination and protection.** It ends a read with a master NACK and then clocks another byte; a slave that keeps transmitting pulls the line during that byte. With write protect raised, a write into the lower half must be acknowledged and leave the data intact, while the upper half still accepts data.

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int ADDR_W  = 8,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_i,
  output logic               sda_pull_o
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_WORD, S_WACK, S_WDATA, S_TX, S_RACK, S_RNEXT, S_WAIT
  } st_t;

  logic [2:0] scl_sy, sda_sy;
  st_t st;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx;
  logic [ADDR_W-1:0] ptr;
  logic pull, rw;
  logic [7:0] mem [DEPTH];

  wire scl_q = scl_sy[1];
  wire scl_d = scl_sy[2];
  wire sda_q = sda_sy[1];
  wire sda_d = sda_sy[2];

  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire start    = scl_q & scl_d & sda_d & ~sda_q;
  wire stop     = scl_q & scl_d & ~sda_d & sda_q;

  wire       addr_hit = rx[7:1] == {DEV_CODE, strap_i};
  wire       locked   = wp_i & ~ptr[ADDR_W-1];
  wire       byte_end = scl_fall & (bitcnt == 4'd8);
  wire       mem_we   = (st == S_WDATA) & byte_end & ~locked;
  wire [7:0] rd_byte  = mem[ptr];

  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
      pull   <= 1'b0;
      rw     <= 1'b0;
    end else if (start) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      pull   <= 1'b0;
    end else if (stop) begin
      st   <= S_IDLE;
      pull <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WORD, S_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx     <= {rx[6:0], sda_q};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (st == S_ADDR) begin
              if (addr_hit) begin
                pull <= 1'b1;
                rw   <= rx[0];
                st   <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              ptr  <= (st == S_WORD) ? rx[ADDR_W-1:0] : ptr + 1'b1;
              pull <= 1'b1;
              st   <= S_WACK;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx     <= rd_byte;
              pull   <= ~rd_byte[7];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              st     <= S_TX;
            end else begin
              pull   <= 1'b0;
              bitcnt <= '0;
              st     <= S_WORD;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            pull   <= 1'b0;
            bitcnt <= '0;
            st     <= S_WDATA;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              pull   <= 1'b0;
              bitcnt <= '0;
              st     <= S_RACK;
            end else begin
              tx   <= {tx[6:0], 1'b0};
              pull <= ~tx[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) st <= sda_q ? S_WAIT : S_RNEXT;
        end
        S_RNEXT: begin
          if (scl_fall) begin
            tx     <= rd_byte;
            pull   <= ~rd_byte[7];
            ptr    <= ptr + 1'b1;
            bitcnt <= '0;
            st     <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull_o); // R10

  AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK && !rw || st == S_WACK) |-> sda_pull_o); // R3

  AST_NO_DRIVE_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR || st == S_WORD || st == S_WDATA) |-> !sda_pull_o); // R11

  AST_QUIET_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_RACK) |-> !sda_pull_o); // R6

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_d) |-> $stable(sda_pull_o)); // R1

  AST_WP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp_i) |-> ptr[ADDR_W-1]); // R8
endmodule

// File: tb/spd_eeprom_slave_tb.sv
module spd_eeprom_slave_tb;
  localparam int Q = 8;
  localparam int H = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic sda_pull;
  wire  sda_bus = ~(m_low | sda_pull);

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [7:0] ref_mem [256];
  int ref_ptr = 0;
  logic last_pull;

  always #2.5 clk = ~clk;

  spd_eeprom_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_low = 1'b1; wclk(H);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(H);
    m_low = 1'b0; wclk(H);
  endtask

  task automatic clk_bit(input logic drive_low, output logic seen);
    m_low = drive_low; wclk(Q);
    m_scl = 1'b1; wclk(H);
    seen = sda_bus;
    last_pull = sda_pull;
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(~b[i], s);
      chk(last_pull, 0, "R11");
    end
    clk_bit(1'b0, s);
    chk(!s, exp_ack, req);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      b[i] = s;
    end
    clk_bit(mack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] sa, input logic rd);
    return {4'b1010, sa, rd};
  endfunction

  task automatic model_write(input logic [7:0] b);
    if (!(wp && ref_ptr < 128)) ref_mem[ref_ptr] = b;
    ref_ptr = (ref_ptr + 1) % 256;
  endtask

  task automatic write_seq(input logic [7:0] at, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), 1'b1, "R3");
    send_byte(at, 1'b1, "R3");
    ref_ptr = at;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], 1'b1, wp ? "R8" : "R3");
      model_write(d[k]);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [7:0] at, input int n, input string req);
    logic [7:0] got;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), 1'b1, "R3");
    send_byte(at, 1'b1, "R3");
    bus_start();
    send_byte(addr_byte(strap, 1'b1), 1'b1, "R9");
    ref_ptr = at;
    for (int k = 0; k < n; k++) begin
      recv_byte(got, k != n - 1);
      chk(got, ref_mem[ref_ptr], req);
      ref_ptr = (ref_ptr + 1) % 256;
    end
  endtask

  initial begin
    logic [7:0] got;
    for (int k = 0; k < 256; k++) ref_mem[k] = 8'h00;
    wclk(5);
    chk(sda_pull, 0, "R10");
    rst_n = 1'b1;
    wclk(5);
    chk(sda_pull, 0, "R10");

    m_scl = 1'b0; wclk(Q);
    send_byte(addr_byte(strap, 1'b0), 1'b0, "R1");
    bus_stop();

    for (int sa = 0; sa < 8; sa++) begin
      strap = 3'(sa);
      bus_start();
      send_byte(addr_byte(3'(sa), 1'b0), 1'b1, "R2");
      bus_stop();
      bus_start();
      send_byte(addr_byte(3'(sa) ^ 3'b010, 1'b0), 1'b0, "R2");
      send_byte(addr_byte(3'(sa), 1'b0), 1'b0, "R2");
      bus_stop();
    end
    strap = 3'b101;

    write_seq(8'h7E, 8'h11, 8'h22, 8'h33, 3);
    write_seq(8'hFE, 8'h44, 8'h55, 8'h66, 3);
    write_seq(8'h10, 8'hA5, 8'h00, 8'h00, 1);

    read_seq(8'h7E, 3, "R5");
    recv_byte(got, 1'b1);
    chk(got, 8'hFF, "R6");
    chk(last_pull, 0, "R6");
    bus_stop();

    read_seq(8'hFE, 3, "R4");
    bus_stop();

    wp = 1'b1;
    write_seq(8'h7F, 8'h77, 8'h88, 8'h00, 2);
    write_seq(8'h10, 8'h5A, 8'h00, 8'h00, 1);
    wp = 1'b0;
    read_seq(8'h7E, 3, "R8");
    bus_stop();
    read_seq(8'h10, 1, "R8");
    bus_stop();

    bus_start();
    send_byte(addr_byte(strap, 1'b0), 1'b1, "R7");
    bus_stop();
    m_scl = 1'b0; wclk(Q);
    send_byte(addr_byte(strap, 1'b0), 1'b0, "R7");
    bus_stop();
    wclk(5);
    chk(sda_pull, 0, "R10");

    finish_run();
  end
endmodule